// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Unit

The unit watches every bus cycle and the instruction-execution status of a processor, and raises a single break request when a programmed condition is met. It has two channels. Each channel compares the bus address under a mask and the address-space identifier (ASID), and qualifies the cycle by bus master, access kind, direction and size. The second channel can also compare the data bus under a mask on data accesses.

Matches on instruction fetches do not break at once. The fetched address is held in a per-channel slot and the break is taken only when that instruction really reaches execution, either before it runs (pre-execution) or before the next instruction that can accept a break (post-execution). Matches on data accesses break one cycle after the bus cycle. Each channel keeps sticky match flags, one for processor cycles and one for DMA cycles. Software clears a flag by writing 0 to it. Events from both channels that fall in the same cycle merge into one request that carries a two-bit break-type code.

Top module: `brk_unit`

## Requirements
- R1: After reset every condition word, flag and request is zero, so no bus cycle can raise a break or set a flag until software writes the registers.
- R2: A channel matches only if the bus address equals its break address in every bit where its mask is 0, and the bus ASID equals its break ASID. Register selects: channel A address 0, ASID 1, mask 2, condition 3; channel B address 4, ASID 5, mask 6, condition 7; channel B data 8, data mask 9, flags 10.
- R3: If any of the three two-bit groups in a condition word is 00, that channel never matches. It raises no request and sets no flag.
- R4: Condition bits: bit0 accepts processor cycles and bit1 accepts DMA cycles (busDma=1). Bit2 accepts fetches and bit3 accepts data accesses. Bit4 accepts reads and bit5 accepts writes.
- R5: Condition bits 7:6 select the size: 0 means any size, 1 byte, 2 word, 3 longword. When the size is not 0 and busSize differs from it, the cycle does not match.
- R6: Channel B also requires busData to equal its data register in every bit where the data mask is 0. This comparison applies on data accesses only and is ignored on fetch cycles.
- R7: A match on a data access gives brkReq one cycle after the bus cycle. The type is 2 (data), or 3 when busIo marks an on-chip I/O or TLB-load access.
- R8: Flags register bits: 0 is A processor, 1 is A DMA, 2 is B processor, 3 is B DMA. A flag sets on a match of its channel and master. It stays set until a write to select 10 puts 0 in its bit. Writing 1 keeps it, and no later match clears it.
- R9: A fetch match stores its address. When exeValid shows that address executing, brkReq rises the next cycle with type 0 (pre-execution). exeFlush discards stored fetches that have not executed.
- R10: When bit 8 is set and the condition is exactly processor, fetch, read and word or longword, the break is post-execution. It gives type 1 one cycle after the next executing instruction that is not a delay slot. With any other condition, bit 8 has no effect.
- R11: A pre-execution break on an instruction executing with exeDelaySlot=1 is dropped. A pending post-execution break skips delay-slot instructions and waits for the next one that can accept a break.
- R12: A post-execution break on an instruction executing with exeSleep=1 is dropped.
- R13: Events in the same cycle give one request. The type is chosen with pre-execution highest, then data, then I/O, then post-execution. All of the matching flags are still set.
- R14: brkReq is a one-cycle pulse for each qualifying access or instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 4 | Register select |
| regWdata | input | DATA_W | Register write data |
| busValid | input | 1 | A bus cycle is present |
| busAddr | input | ADDR_W | Bus address |
| busAsid | input | ASID_W | Address-space identifier of the cycle |
| busData | input | DATA_W | Bus data |
| busDma | input | 1 | 1 for a DMA cycle, 0 for a processor cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busFetch | input | 1 | 1 for instruction fetch, 0 for data access |
| busIo | input | 1 | On-chip I/O or TLB-load access |
| busSize | input | 2 | 1 byte, 2 word, 3 longword |
| exeValid | input | 1 | An instruction enters execution |
| exeAddr | input | ADDR_W | Address of the executing instruction |
| exeDelaySlot | input | 1 | Executing instruction sits in a delay slot |
| exeSleep | input | 1 | Executing instruction is a sleep |
| exeFlush | input | 1 | Fetched but unexecuted instructions are discarded |
| brkReq | output | 1 | Break request pulse |
| brkType | output | 2 | 0 pre, 1 post, 2 data, 3 I/O or TLB load |
| matchFlags | output | 4 | Sticky match flags |

## Verification
The comparators are driven with a table of data cycles whose addresses fall inside and just outside the masked window, with a wrong ASID, with each master, direction and size, and with data that differs only in compared or only in masked bits. This tells the address, ASID, qualifier and data checks apart. Fetch sequences then separate the pre-execution and post-execution paths: a flushed fetch, an execution in a delay slot, a sleep, and an exact versus a loose condition for the post bit. A final cycle puts a data hit and a pre-execution hit together, which separates request merging from flag setting.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NUM_CH      = 2;
  localparam int DATA_CH     = 1;
  localparam int REGS_PER_CH = 4;
  localparam int FLAG_W      = 2 * NUM_CH;

  // per-channel register offsets
  localparam logic [3:0] OFS_ADDR = 4'd0;
  localparam logic [3:0] OFS_ASID = 4'd1;
  localparam logic [3:0] OFS_MASK = 4'd2;
  localparam logic [3:0] OFS_COND = 4'd3;
  // shared registers
  localparam logic [3:0] SEL_DATA  = 4'd8;
  localparam logic [3:0] SEL_DMASK = 4'd9;
  localparam logic [3:0] SEL_FLAGS = 4'd10;

  // condition word bits
  localparam int CB_CPU   = 0;
  localparam int CB_DMA   = 1;
  localparam int CB_FETCH = 2;
  localparam int CB_DATA  = 3;
  localparam int CB_READ  = 4;
  localparam int CB_WRITE = 5;
  localparam int CB_SZ_LO = 6;
  localparam int CB_SZ_HI = 7;
  localparam int CB_POST  = 8;
  localparam int COND_W   = 9;

  localparam logic [1:0] SZ_ANY  = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_LONG = 2'd3;

  typedef enum logic [1:0] {
    BRK_PRE  = 2'b00,
    BRK_POST = 2'b01,
    BRK_DATA = 2'b10,
    BRK_IO   = 2'b11
  } brk_type_e;

  // strobes from the comparator datapath to the control
  typedef struct packed {
    logic [NUM_CH-1:0] hitCpu;
    logic [NUM_CH-1:0] hitDma;
    logic [NUM_CH-1:0] postSel;
    logic              cycFetch;
    logic              cycIo;
  } brk_strobe_t;
endpackage

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ASID_W-1:0] busAsid,
  input  logic [DATA_W-1:0] busData,
  input  logic              busDma,
  input  logic              busWrite,
  input  logic              busFetch,
  input  logic              busIo,
  input  logic [1:0]        busSize,
  output brk_strobe_t       strb
);
  logic [NUM_CH-1:0] hitCpuV;
  logic [NUM_CH-1:0] hitDmaV;
  logic [NUM_CH-1:0] postSelV;

  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] dmaskQ;
  logic              dataCmpOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ  <= '0;
      dmaskQ <= '0;
    end else if (regWe) begin
      if (regSel == SEL_DATA)  dataQ  <= regWdata;
      if (regSel == SEL_DMASK) dmaskQ <= regWdata;
    end
  end

  // data compare only counts on data accesses
  assign dataCmpOk = busFetch || (((busData ^ dataQ) & ~dmaskQ) == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [3:0] Base = 4'(ch * REGS_PER_CH);

    logic [ADDR_W-1:0] addrQ;
    logic [ADDR_W-1:0] maskQ;
    logic [ASID_W-1:0] asidQ;
    logic [COND_W-1:0] condQ;
    logic groupsOn, masterOk, kindOk, dirOk, sizeOk, addrOk, asidOk, dataOk, hit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ <= '0;
        maskQ <= '0;
        asidQ <= '0;
        condQ <= '0;
      end else if (regWe) begin
        if (regSel == Base + OFS_ADDR) addrQ <= regWdata[ADDR_W-1:0];
        if (regSel == Base + OFS_ASID) asidQ <= regWdata[ASID_W-1:0];
        if (regSel == Base + OFS_MASK) maskQ <= regWdata[ADDR_W-1:0];
        if (regSel == Base + OFS_COND) condQ <= regWdata[COND_W-1:0];
      end
    end

    if (ch == DATA_CH) begin : g_data
      assign dataOk = dataCmpOk;
    end else begin : g_nodata
      assign dataOk = 1'b1;
    end

    assign groupsOn = (condQ[CB_DMA:CB_CPU] != 2'b00) &&
                      (condQ[CB_DATA:CB_FETCH] != 2'b00) &&
                      (condQ[CB_WRITE:CB_READ] != 2'b00);
    assign masterOk = busDma   ? condQ[CB_DMA]   : condQ[CB_CPU];
    assign kindOk   = busFetch ? condQ[CB_FETCH] : condQ[CB_DATA];
    assign dirOk    = busWrite ? condQ[CB_WRITE] : condQ[CB_READ];
    assign sizeOk   = (condQ[CB_SZ_HI:CB_SZ_LO] == SZ_ANY) ||
                      (condQ[CB_SZ_HI:CB_SZ_LO] == busSize);
    assign addrOk   = ((busAddr ^ addrQ) & ~maskQ) == '0;
    assign asidOk   = busAsid == asidQ;

    assign hit = busValid && groupsOn && masterOk && kindOk && dirOk &&
                 sizeOk && addrOk && asidOk && dataOk;

    assign hitCpuV[ch] = hit && !busDma;
    assign hitDmaV[ch] = hit && busDma;

    // post-execution only on exact cpu/fetch/read/word-or-long conditions
    assign postSelV[ch] = condQ[CB_POST] &&
                          (condQ[CB_DMA:CB_CPU] == 2'b01) &&
                          (condQ[CB_DATA:CB_FETCH] == 2'b01) &&
                          (condQ[CB_WRITE:CB_READ] == 2'b01) &&
                          ((condQ[CB_SZ_HI:CB_SZ_LO] == SZ_WORD) ||
                           (condQ[CB_SZ_HI:CB_SZ_LO] == SZ_LONG));
  end

  assign strb = '{hitCpu: hitCpuV, hitDma: hitDmaV, postSel: postSelV,
                  cycFetch: busFetch, cycIo: busIo};
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  brk_strobe_t       strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              flagWe,
  input  logic [FLAG_W-1:0] flagWdata,
  input  logic              exeValid,
  input  logic [ADDR_W-1:0] exeAddr,
  input  logic              exeDelaySlot,
  input  logic              exeSleep,
  input  logic              exeFlush,
  output logic              brkReq,
  output logic [1:0]        brkType,
  output logic [FLAG_W-1:0] matchFlags
);
  logic [FLAG_W-1:0] flagQ;
  logic [FLAG_W-1:0] flagSet;
  logic [NUM_CH-1:0] anyHit;
  logic [NUM_CH-1:0] preFire;
  logic [NUM_CH-1:0] armPost;
  logic              exeAccept;
  logic              postArmQ;
  logic              postFire;
  logic              dataFire;
  logic              ioFire;
  logic              reqQ;
  brk_type_e         typeQ;

  assign exeAccept = exeValid && !exeDelaySlot;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic              pendV;
    logic [ADDR_W-1:0] pendAddr;
    logic              pendPost;
    logic              fetchHit;
    logic              exeHit;

    assign anyHit[ch]        = strb.hitCpu[ch] || strb.hitDma[ch];
    assign flagSet[2*ch]     = strb.hitCpu[ch];
    assign flagSet[2*ch + 1] = strb.hitDma[ch];
    assign fetchHit          = anyHit[ch] && strb.cycFetch;
    assign exeHit            = exeValid && pendV && (exeAddr == pendAddr);
    assign preFire[ch]       = exeHit && !pendPost && !exeDelaySlot;
    assign armPost[ch]       = exeHit && pendPost && !exeSleep;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendV    <= 1'b0;
        pendAddr <= '0;
        pendPost <= 1'b0;
      end else if (fetchHit) begin
        pendV    <= 1'b1;
        pendAddr <= busAddr;
        pendPost <= strb.postSel[ch];
      end else if (exeFlush || exeHit) begin
        pendV    <= 1'b0;
      end
    end
  end

  assign postFire = postArmQ && exeAccept;
  assign dataFire = (|anyHit) && !strb.cycFetch && !strb.cycIo;
  assign ioFire   = (|anyHit) && !strb.cycFetch && strb.cycIo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ    <= '0;
      postArmQ <= 1'b0;
      reqQ     <= 1'b0;
      typeQ    <= BRK_PRE;
    end else begin
      flagQ    <= (flagQ & (flagWe ? flagWdata : '1)) | flagSet;
      postArmQ <= (|armPost) || (postArmQ && !postFire);
      reqQ     <= (|preFire) || dataFire || ioFire || postFire;
      if (|preFire)      typeQ <= BRK_PRE;
      else if (dataFire) typeQ <= BRK_DATA;
      else if (ioFire)   typeQ <= BRK_IO;
      else if (postFire) typeQ <= BRK_POST;
    end
  end

  assign brkReq     = reqQ;
  assign brkType    = typeQ;
  assign matchFlags = flagQ;

  // R8: a set flag survives anything but a zero written to its bit
  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag_chk
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[i] && !(flagWe && !flagWdata[i])) |=> flagQ[i]);
  end

  // R7: a data-type request follows a data-access match
  assert_data_follows_hit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq && typeQ == BRK_DATA) |-> $past((|(strb.hitCpu | strb.hitDma)) && !strb.cycFetch));

  // R9: a pre-execution request follows an executing non-delay-slot instruction
  assert_pre_on_exec_R9: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq && typeQ == BRK_PRE) |-> $past(exeValid && !exeDelaySlot));

  // R10: a post-execution request follows an instruction able to accept it
  assert_post_on_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq && typeQ == BRK_POST) |-> $past(exeValid && !exeDelaySlot));

  // R12: a sleep instruction never arms a post-execution break
  assert_no_post_on_sleep_R12: assert property (@(posedge clk) disable iff (!rstN)
    (exeValid && exeSleep && !postArmQ) |=> !postArmQ);
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ASID_W-1:0] busAsid,
  input  logic [DATA_W-1:0] busData,
  input  logic              busDma,
  input  logic              busWrite,
  input  logic              busFetch,
  input  logic              busIo,
  input  logic [1:0]        busSize,
  input  logic              exeValid,
  input  logic [ADDR_W-1:0] exeAddr,
  input  logic              exeDelaySlot,
  input  logic              exeSleep,
  input  logic              exeFlush,
  output logic              brkReq,
  output logic [1:0]        brkType,
  output logic [3:0]        matchFlags
);
  brk_strobe_t strb;
  logic        flagWe;

  assign flagWe = regWe && (regSel == SEL_FLAGS);

  brk_match #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .DATA_W(DATA_W)) u_match (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .busValid(busValid), .busAddr(busAddr), .busAsid(busAsid), .busData(busData),
    .busDma(busDma), .busWrite(busWrite), .busFetch(busFetch), .busIo(busIo),
    .busSize(busSize), .strb(strb)
  );

  brk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .flagWe(flagWe), .flagWdata(regWdata[FLAG_W-1:0]),
    .exeValid(exeValid), .exeAddr(exeAddr), .exeDelaySlot(exeDelaySlot),
    .exeSleep(exeSleep), .exeFlush(exeFlush),
    .brkReq(brkReq), .brkType(brkType), .matchFlags(matchFlags)
  );
endmodule

// File: tb/brk_unit_bench.sv
module brk_unit_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic [7:0]  asid;
    logic [31:0] data;
    logic        dma;
    logic        wr;
    logic        fetch;
    logic        io;
    logic [1:0]  size;
    logic        expReq;
    logic [1:0]  expType;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h1000_0040, 8'd5, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 2'd2},
    '{32'h1000_004F, 8'd5, 32'h0,         1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 2'd2},
    '{32'h1000_0050, 8'd5, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 2'd0},
    '{32'h1000_0040, 8'd6, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 2'd0},
    '{32'h1000_0041, 8'd5, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 2'd3},
    '{32'h1000_0040, 8'd5, 32'h0,         1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 2'd0},
    '{32'h2000_0000, 8'd7, 32'h1234_AB56, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 2'd2},
    '{32'h2000_0000, 8'd7, 32'h1234_AC56, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 2'd0},
    '{32'h2000_0000, 8'd7, 32'h0000_AB00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 2'd0},
    '{32'h2000_0000, 8'd7, 32'h0000_AB00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 2'd0},
    '{32'h2000_0000, 8'd7, 32'h0000_AB00, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic [7:0]  busAsid = '0;
  logic [31:0] busData = '0;
  logic        busDma = 1'b0;
  logic        busWrite = 1'b0;
  logic        busFetch = 1'b0;
  logic        busIo = 1'b0;
  logic [1:0]  busSize = '0;
  logic        exeValid = 1'b0;
  logic [31:0] exeAddr = '0;
  logic        exeDelaySlot = 1'b0;
  logic        exeSleep = 1'b0;
  logic        exeFlush = 1'b0;
  logic        brkReq;
  logic [1:0]  brkType;
  logic [3:0]  matchFlags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  brk_unit u_brk_unit (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .busValid(busValid), .busAddr(busAddr), .busAsid(busAsid), .busData(busData),
    .busDma(busDma), .busWrite(busWrite), .busFetch(busFetch), .busIo(busIo),
    .busSize(busSize), .exeValid(exeValid), .exeAddr(exeAddr),
    .exeDelaySlot(exeDelaySlot), .exeSleep(exeSleep), .exeFlush(exeFlush),
    .brkReq(brkReq), .brkType(brkType), .matchFlags(matchFlags)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] sel, input logic [31:0] val);
    regWe = 1'b1; regSel = sel; regWdata = val;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic driveBus(input logic [31:0] a, input logic [7:0] s, input logic [31:0] d,
                          input logic dma, input logic wr, input logic fe,
                          input logic io, input logic [1:0] sz);
    busValid = 1'b1; busAddr = a; busAsid = s; busData = d;
    busDma = dma; busWrite = wr; busFetch = fe; busIo = io; busSize = sz;
  endtask

  task automatic busCycle(input logic [31:0] a, input logic [7:0] s, input logic [31:0] d,
                          input logic dma, input logic wr, input logic fe,
                          input logic io, input logic [1:0] sz);
    driveBus(a, s, d, dma, wr, fe, io, sz);
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic exeStep(input logic [31:0] a, input logic ds, input logic sl);
    exeValid = 1'b1; exeAddr = a; exeDelaySlot = ds; exeSleep = sl;
    @(negedge clk);
    exeValid = 1'b0; exeDelaySlot = 1'b0; exeSleep = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, and default registers give no break
    check("R1 reset req", 32'(brkReq), 32'd0);
    check("R1 reset flags", 32'(matchFlags), 32'd0);
    busCycle(32'h0, 8'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1);
    check("R1 no break from reset config", 32'(brkReq), 32'd0);
    check("R1 no flag from reset config", 32'(matchFlags), 32'd0);

    // channel A: data, any master, any direction, any size, low nibble masked
    writeReg(4'd0, 32'h1000_0040);
    writeReg(4'd1, 32'd5);
    writeReg(4'd2, 32'h0000_000F);
    writeReg(4'd3, 32'h03B);
    // channel B: cpu, data, write, longword, data byte 15:8 compared
    writeReg(4'd4, 32'h2000_0000);
    writeReg(4'd5, 32'd7);
    writeReg(4'd6, 32'h0);
    writeReg(4'd7, 32'h0E9);
    writeReg(4'd8, 32'h0000_AB00);
    writeReg(4'd9, 32'hFFFF_00FF);

    // R2 R4 R5 R6 R7: table of data cycles
    for (int i = 0; i < NV; i++) begin
      busCycle(VECS[i].addr, VECS[i].asid, VECS[i].data, VECS[i].dma, VECS[i].wr,
               VECS[i].fetch, VECS[i].io, VECS[i].size);
      check($sformatf("R2 R7 vector %0d req", i), 32'(brkReq), 32'(VECS[i].expReq));
      if (VECS[i].expReq) check($sformatf("R7 vector %0d type", i), 32'(brkType), 32'(VECS[i].expType));
      @(negedge clk);
      check($sformatf("R14 vector %0d pulse low", i), 32'(brkReq), 32'd0);
    end
    check("R8 flags after table", 32'(matchFlags), 32'h7);

    // R8: clear by writing zero, keep by writing one
    writeReg(4'd10, 32'hE);
    check("R8 clear A cpu", 32'(matchFlags), 32'h6);
    busCycle(32'h1000_0050, 8'd5, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1);
    check("R8 miss keeps flags", 32'(matchFlags), 32'h6);
    writeReg(4'd10, 32'h0);
    check("R8 clear all", 32'(matchFlags), 32'h0);

    // R3: a zero group disables the channel
    writeReg(4'd3, 32'h038);
    busCycle(32'h1000_0040, 8'd5, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1);
    check("R3 master group zero req", 32'(brkReq), 32'd0);
    writeReg(4'd3, 32'h033);
    busCycle(32'h1000_0040, 8'd5, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1);
    check("R3 kind group zero req", 32'(brkReq), 32'd0);
    check("R3 no flags", 32'(matchFlags), 32'h0);

    // R6 R9: channel B fetch, data ignored, pre-execution
    writeReg(4'd7, 32'h015);
    busCycle(32'h2000_0000, 8'd7, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
    check("R9 fetch alone no req", 32'(brkReq), 32'd0);
    check("R6 fetch matched despite data", 32'(matchFlags), 32'h4);
    exeStep(32'h2000_0000, 1'b0, 1'b0);
    check("R9 pre req", 32'(brkReq), 32'd1);
    check("R9 pre type", 32'(brkType), 32'd0);
    @(negedge clk);
    check("R14 pre pulse low", 32'(brkReq), 32'd0);

    // R9: flush discards
    busCycle(32'h2000_0000, 8'd7, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
    exeFlush = 1'b1; @(negedge clk); exeFlush = 1'b0;
    exeStep(32'h2000_0000, 1'b0, 1'b0);
    check("R9 flushed fetch no req", 32'(brkReq), 32'd0);

    // R11: pre-execution on a delay slot is dropped
    busCycle(32'h2000_0000, 8'd7, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
    exeStep(32'h2000_0000, 1'b1, 1'b0);
    check("R11 pre on delay slot dropped", 32'(brkReq), 32'd0);
    exeStep(32'h2000_0002, 1'b0, 1'b0);
    check("R11 nothing later", 32'(brkReq), 32'd0);

    // R10: post-execution on exact condition
    writeReg(4'd7, 32'h0);
    writeReg(4'd3, 32'h195);
    busCycle(32'h1000_0040, 8'd5, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
    exeStep(32'h1000_0040, 1'b0, 1'b0);
    check("R10 no req on own execution", 32'(brkReq), 32'd0);
    exeStep(32'h1000_0042, 1'b0, 1'b0);
    check("R10 post req", 32'(brkReq), 32'd1);
    check("R10 post type", 32'(brkType), 32'd1);

    // R11: post deferred over a delay slot
    busCycle(32'h1000_0040, 8'd5, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
    exeStep(32'h1000_0040, 1'b0, 1'b0);
    exeStep(32'h1000_0042, 1'b1, 1'b0);
    check("R11 deferred over delay slot", 32'(brkReq), 32'd0);
    exeStep(32'h1000_0044, 1'b0, 1'b0);
    check("R11 deferred req", 32'(brkReq), 32'd1);
    check("R11 deferred type", 32'(brkType), 32'd1);

    // R12: post on sleep dropped
    busCycle(32'h1000_0040, 8'd5, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
    exeStep(32'h1000_0040, 1'b0, 1'b1);
    exeStep(32'h1000_0042, 1'b0, 1'b0);
    check("R12 sleep post dropped", 32'(brkReq), 32'd0);

    // R5: size mismatch on fetch blocks the match
    busCycle(32'h1000_0040, 8'd5, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3);
    exeStep(32'h1000_0040, 1'b0, 1'b0);
    exeStep(32'h1000_0042, 1'b0, 1'b0);
    check("R5 size mismatch no req", 32'(brkReq), 32'd0);

    // R10: post bit ignored with size any
    writeReg(4'd3, 32'h115);
    busCycle(32'h1000_0040, 8'd5, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
    exeStep(32'h1000_0040, 1'b0, 1'b0);
    check("R10 loose condition req", 32'(brkReq), 32'd1);
    check("R10 loose condition is pre", 32'(brkType), 32'd0);

    // R13: data hit on A and pre hit on B together
    writeReg(4'd3, 32'h03B);
    writeReg(4'd7, 32'h015);
    busCycle(32'h2000_0000, 8'd7, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
    writeReg(4'd10, 32'h0);
    driveBus(32'h1000_0040, 8'd5, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1);
    exeValid = 1'b1; exeAddr = 32'h2000_0000;
    @(negedge clk);
    busValid = 1'b0; exeValid = 1'b0;
    check("R13 merged req", 32'(brkReq), 32'd1);
    check("R13 merged type pre", 32'(brkType), 32'd0);
    @(negedge clk);
    check("R13 single pulse", 32'(brkReq), 32'd0);
    check("R13 flag A set", 32'(matchFlags), 32'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule